// File: doc/BRIEF.md
# Reloading Timer Pair with Rate Ticker and Watchdog

This peripheral gives a small microcontroller two 16-bit reloading down-counters, a fixed-rate ticker and a watchdog, all reached through a byte-wide register port with a 3-bit offset. Writes take effect at the clock edge. Reads are combinational and have no side effects. The two counters share one clock choice. They count either on every system clock or only on cycles where the low-rate tick enable is high. That enable stands for a 32.768 kHz source and arrives as a one-cycle pulse in the system clock domain. When a counter passes through zero it reloads and raises a one-cycle event.

The ticker divides the low-rate tick by a power of two, selected by a 4-bit rate code. The watchdog counts the same tick. If software fails to write the kick register in time, the watchdog emits a one-cycle chip reset pulse. Each source sets a sticky flag in a status register, which software clears by writing ones. Each interrupt request is a flag gated by its own enable.

Register offsets: 0 = timer A reload low byte, 1 = timer A reload high byte, 2 = timer B reload low byte, 3 = timer B reload high byte, 4 = control, 5 = rate, 6 = status, 7 = kick.

Top module: `tmr_wdog_unit`

## Requirements
- R1: Offsets 0–3 hold the two reload values (A low, A high, B low, B high), each written and read back as a byte. Offset 7 reads as 0.
- R2: When its enable bit is set, a timer loaded with value V emits a one-cycle event every V+1 counting ticks (evt_a, evt_b). A disabled timer emits no event and sits at its reload value.
- R3: Control bit 4 picks the counting tick. At 0 the timers count on every clock. At 1 they count only on cycles where slow_tick is high.
- R4: After reset, all reload values and flags are 0. The control register reads 0, so both timers are off, all interrupt enables are off and the watchdog is on. The interrupt requests are: irq_a = status bit 0 AND control bit 2; irq_b = status bit 1 AND control bit 3; irq_fix = status bit 2 AND control bit 5. Control bits 0 and 1 enable timers A and B.
- R5: Rate register bits 3:0 form the ticker code. With bit 3 clear the ticker is off and its divider is held at 0. With bit 3 set and bits 2:0 = k, the ticker fires every 512·2^k slow ticks, so code 8 gives 64 Hz and code 15 gives 0.5 Hz. The first event comes 512·2^k slow ticks after the ticker is switched on.
- R6: While the watchdog is enabled, wdt_rst pulses for one cycle once 65536 slow ticks have passed since the last restart. The count then starts again from zero.
- R7: Any write to offset 7, whatever the data, restarts the watchdog count, and no reset pulse follows in the next cycle.
- R8: Status offset 6 holds bit 0 = timer A event, bit 1 = timer B event and bit 2 = ticker event. Each flag is set in the cycle after its event and stays set. Writing a 1 to a bit clears it, and a 0 bit has no effect. A new event wins over a clear in the same cycle.
- R9: A reload value written while its timer runs does not disturb the current period. It is used from the next reload onwards.
- R10: Control bit 6 set to 1 stops the watchdog and holds its count at zero, so no wdt_rst is produced however long the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable for each 32.768 kHz tick |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| evt_a | output | 1 | Timer A event pulse |
| evt_b | output | 1 | Timer B event pulse |
| irq_a | output | 1 | Timer A interrupt request |
| irq_b | output | 1 | Timer B interrupt request |
| irq_fix | output | 1 | Ticker interrupt request |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The assertions assume that bus_wr is never X while reset is released and that slow_tick arrives as isolated one-cycle pulses. They also assume the watchdog timeout spans at least two slow ticks, so two reset pulses can never be adjacent. The stimulus drives every input only at falling edges. It generates slow_tick from a fixed divider of one or three clocks. It performs register writes one per strobe and never holds a write across cycles, so each write asserted on is a single, clean access.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the timer/watchdog unit.
// Assumes a byte-wide register port with a 3-bit offset.
package tmr_pkg;

    localparam int TMR_W  = 16;   // reload counter width (two bytes)
    localparam int ADDR_W = 3;    // register offset width

    localparam logic [ADDR_W-1:0] A_RLA_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_RLA_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLB_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLB_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_RATE   = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd6;
    localparam logic [ADDR_W-1:0] A_KICK   = 3'd7;

    // Control register layout, bit 6 down to bit 0.
    typedef struct packed {
        logic wdt_off;
        logic ie_fix;
        logic slow_sel;
        logic ie_b;
        logic ie_a;
        logic en_b;
        logic en_a;
    } ctrl_t;

endpackage

// File: rtl/tmr_reload_ctr.sv
// Reloading down-counter. Loaded from `reload` while disabled.
// When enabled it decrements on each `tick`. On a tick at zero it
// reloads and raises `evt` for one cycle (registered).
// Assumes `reload` is stable or only changes at register writes.
module tmr_reload_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic         evt
);

    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);

    // Count, reload and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= en & tick & at_zero;
            if (!en)
                cnt_q <= reload;
            else if (tick)
                cnt_q <= at_zero ? reload : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/tmr_rate_tick.sv
// Power-of-two rate ticker on the slow tick. Code bit 3 enables it,
// and bits 2:0 add to BASE_SH to give the log2 of the period in
// slow ticks. Assumes PRE_W >= BASE_SH + 7.
module tmr_rate_tick #(
    parameter int PRE_W   = 16,
    parameter int BASE_SH = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic [3:0] code,
    output logic       evt
);

    localparam int SPAN_W = PRE_W + 1;

    logic [PRE_W-1:0]  pre_q;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] span_m1;
    logic [PRE_W-1:0]  mask;

    // Period mask for the selected code.
    always_comb begin
        span    = SPAN_W'(1) << (BASE_SH + int'(code[2:0]));
        span_m1 = span - 1'b1;
        mask    = span_m1[PRE_W-1:0];
    end

    // Divider advance and event at the last tick of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= code[3] & slow_tick & ((pre_q & mask) == mask);
            if (!code[3])
                pre_q <= '0;
            else if (slow_tick)
                pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_wdog.sv
// Watchdog counting slow ticks. A kick or disable clears the count.
// It barks for one cycle on the tick that wraps the count.
// Assumes W >= 1, so the timeout is at least two ticks.
module tmr_wdog #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic enable,
    input  logic kick,
    output logic bark
);

    logic [W-1:0] cnt_q;

    // Count, clear and timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bark  <= 1'b0;
        end else begin
            bark <= enable & ~kick & slow_tick & (&cnt_q);
            if (kick || !enable)
                cnt_q <= '0;
            else if (slow_tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_wdog_unit.sv
// Timer unit top: byte register file, two reloading timers, rate
// ticker, watchdog, sticky status and interrupt gating.
// Assumes single-cycle write strobes and a slow_tick enable pulse.
module tmr_wdog_unit
    import tmr_pkg::*;
#(
    parameter int WDT_W   = 16,
    parameter int PRE_W   = 16,
    parameter int BASE_SH = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              evt_a,
    output logic              evt_b,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_fix,
    output logic              wdt_rst
);

    localparam int N_TMR  = 2;
    localparam int N_FLAG = N_TMR + 1;

    logic [N_TMR-1:0][TMR_W-1:0] rl_q;
    ctrl_t                        ctrl_q;
    logic [3:0]                   rate_q;
    logic [N_FLAG-1:0]            flag_q;
    logic [N_FLAG-1:0]            clr_bits;
    logic [N_TMR-1:0]             tmr_en;
    logic [N_TMR-1:0]             tmr_evt;
    logic                         tmr_tick;
    logic                         fix_evt;
    logic                         kick;

    assign tmr_en   = {ctrl_q.en_b, ctrl_q.en_a};
    assign tmr_tick = ctrl_q.slow_sel ? slow_tick : 1'b1;
    assign kick     = bus_wr && (bus_addr == A_KICK);
    assign clr_bits = (bus_wr && bus_addr == A_STAT) ? bus_wdata[N_FLAG-1:0] : '0;

    // One reloading counter per timer.
    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        tmr_reload_ctr #(.W(TMR_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (tmr_en[i]),
            .tick   (tmr_tick),
            .reload (rl_q[i]),
            .evt    (tmr_evt[i])
        );
    end

    tmr_rate_tick #(.PRE_W(PRE_W), .BASE_SH(BASE_SH)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .code      (rate_q),
        .evt       (fix_evt)
    );

    tmr_wdog #(.W(WDT_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .enable    (~ctrl_q.wdt_off),
        .kick      (kick),
        .bark      (wdt_rst)
    );

    // Register writes and sticky flag update (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rl_q   <= '0;
            ctrl_q <= '0;
            rate_q <= '0;
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_bits) | {fix_evt, tmr_evt};
            if (bus_wr) begin
                case (bus_addr)
                    A_RLA_LO: rl_q[0][7:0]  <= bus_wdata;
                    A_RLA_HI: rl_q[0][15:8] <= bus_wdata;
                    A_RLB_LO: rl_q[1][7:0]  <= bus_wdata;
                    A_RLB_HI: rl_q[1][15:8] <= bus_wdata;
                    A_CTRL:   ctrl_q        <= ctrl_t'(bus_wdata[6:0]);
                    A_RATE:   rate_q        <= bus_wdata[3:0];
                    default:  ;
                endcase
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_RLA_LO: bus_rdata = rl_q[0][7:0];
            A_RLA_HI: bus_rdata = rl_q[0][15:8];
            A_RLB_LO: bus_rdata = rl_q[1][7:0];
            A_RLB_HI: bus_rdata = rl_q[1][15:8];
            A_CTRL:   bus_rdata = {1'b0, ctrl_q};
            A_RATE:   bus_rdata = {4'b0, rate_q};
            A_STAT:   bus_rdata = {5'b0, flag_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign evt_a   = tmr_evt[0];
    assign evt_b   = tmr_evt[1];
    assign irq_a   = flag_q[0] & ctrl_q.ie_a;
    assign irq_b   = flag_q[1] & ctrl_q.ie_b;
    assign irq_fix = flag_q[2] & ctrl_q.ie_fix;

endmodule

// File: rtl/tmr_wdog_unit_chk.sv
// Assertion checker for tmr_wdog_unit, attached by bind below.
// Assumes a synchronous active-low reset and the default offset map.
module tmr_wdog_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       evt_a,
    input logic       evt_b,
    input logic       irq_a,
    input logic       irq_b,
    input logic       irq_fix,
    input logic       wdt_rst,
    input logic [6:0] ctrl,
    input logic [3:0] rate,
    input logic [2:0] flag,
    input logic       fix_evt
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !irq_a && !irq_b && !irq_fix && !wdt_rst); // R4
    AST_IDLE_A:      assert property (@(posedge clk) disable iff (!rst_n) !ctrl[0] |=> !evt_a); // R2
    AST_IDLE_B:      assert property (@(posedge clk) disable iff (!rst_n) !ctrl[1] |=> !evt_b); // R2
    AST_FLAG_A_SET:  assert property (@(posedge clk) disable iff (!rst_n) evt_a |=> flag[0]); // R8
    AST_FLAG_B_SET:  assert property (@(posedge clk) disable iff (!rst_n) evt_b |=> flag[1]); // R8
    AST_FIX_OFF:     assert property (@(posedge clk) disable iff (!rst_n) !rate[3] |=> !fix_evt); // R5
    AST_WDT_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |=> !wdt_rst); // R6
    AST_WDT_KICK:    assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == 3'd7) |=> !wdt_rst); // R7
    AST_WDT_OFF:     assert property (@(posedge clk) disable iff (!rst_n) ctrl[6] |=> !wdt_rst); // R10

endmodule

bind tmr_wdog_unit tmr_wdog_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .evt_a    (evt_a),
    .evt_b    (evt_b),
    .irq_a    (irq_a),
    .irq_b    (irq_b),
    .irq_fix  (irq_fix),
    .wdt_rst  (wdt_rst),
    .ctrl     (ctrl_q),
    .rate     (rate_q),
    .flag     (flag_q),
    .fix_evt  (fix_evt)
);

// File: tb/tmr_wdog_unit_test.sv
// Bench for tmr_wdog_unit: behavioural reference compared every clock
// plus directed checks of periods, flags, rates and watchdog timing.
module tmr_wdog_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WDT_SPAN   = 65536;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       evt_a, evt_b, irq_a, irq_b, irq_fix, wdt_rst;

    int tests = 0;
    int fails = 0;
    int slow_per = 1;
    int wdt_pulses = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_wdog_unit uut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_a(evt_a), .evt_b(evt_b),
        .irq_a(irq_a), .irq_b(irq_b), .irq_fix(irq_fix), .wdt_rst(wdt_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // ---------------- reference model ----------------
    int m_rl[2];
    int m_cnt[2];
    bit m_evt[2];
    int m_ctrl, m_rate, m_flag, m_pre, m_wcnt;
    bit m_fevt, m_wrst;
    bit m_live = 1'b0;

    function automatic int m_read(input int a);
        case (a)
            0: return m_rl[0] & 255;
            1: return m_rl[0] >> 8;
            2: return m_rl[1] & 255;
            3: return m_rl[1] >> 8;
            4: return m_ctrl;
            5: return m_rate;
            6: return m_flag;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rl[0] = 0; m_rl[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
            m_evt[0] = 0; m_evt[1] = 0; m_ctrl = 0; m_rate = 0; m_flag = 0;
            m_pre = 0; m_wcnt = 0; m_fevt = 0; m_wrst = 0;
            m_live = 1'b0;
        end else begin
            bit tk, kk, wen, nf, nw;
            bit ne[2];
            int clr, per;
            tk  = m_ctrl[4] ? slow_tick : 1'b1;
            clr = (bus_wr && bus_addr == 3'd6) ? (bus_wdata & 7) : 0;
            m_flag = (m_flag & ~clr & 7) | (m_fevt << 2) | (m_evt[1] << 1) | m_evt[0];
            for (int i = 0; i < 2; i++) begin
                bit en;
                en = m_ctrl[i];
                ne[i] = en && tk && m_cnt[i] == 0;
                if (!en) m_cnt[i] = m_rl[i];
                else if (tk) m_cnt[i] = (m_cnt[i] == 0) ? m_rl[i] : m_cnt[i] - 1;
            end
            per = 512 << (m_rate & 7);
            nf  = m_rate[3] && slow_tick && (m_pre % per == per - 1);
            m_pre = m_rate[3] ? (slow_tick ? (m_pre + 1) % 65536 : m_pre) : 0;
            wen = !m_ctrl[6];
            kk  = bus_wr && bus_addr == 3'd7;
            nw  = wen && !kk && slow_tick && m_wcnt == WDT_SPAN - 1;
            m_wcnt = (kk || !wen) ? 0 : (slow_tick ? (m_wcnt + 1) % WDT_SPAN : m_wcnt);
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_rl[0] = (m_rl[0] & 16'hFF00) | bus_wdata;
                    3'd1: m_rl[0] = (m_rl[0] & 16'h00FF) | (int'(bus_wdata) << 8);
                    3'd2: m_rl[1] = (m_rl[1] & 16'hFF00) | bus_wdata;
                    3'd3: m_rl[1] = (m_rl[1] & 16'h00FF) | (int'(bus_wdata) << 8);
                    3'd4: m_ctrl = bus_wdata & 127;
                    3'd5: m_rate = bus_wdata & 15;
                    default: ;
                endcase
            end
            m_evt[0] = ne[0]; m_evt[1] = ne[1]; m_fevt = nf; m_wrst = nw;
            m_live = 1'b1;
        end
        #1;
        if (m_live && !done) begin
            check(evt_a == m_evt[0], "R2 evt_a vs model", evt_a, m_evt[0]);
            check(evt_b == m_evt[1], "R2 evt_b vs model", evt_b, m_evt[1]);
            check(irq_a == (m_flag[0] & m_ctrl[2]), "R4 irq_a vs model", irq_a, m_flag[0] & m_ctrl[2]);
            check(irq_b == (m_flag[1] & m_ctrl[3]), "R4 irq_b vs model", irq_b, m_flag[1] & m_ctrl[3]);
            check(irq_fix == (m_flag[2] & m_ctrl[5]), "R5 irq_fix vs model", irq_fix, m_flag[2] & m_ctrl[5]);
            check(wdt_rst == m_wrst, "R6 wdt_rst vs model", wdt_rst, m_wrst);
            check(int'(bus_rdata) == m_read(int'(bus_addr)), "R1 rdata vs model", bus_rdata, m_read(int'(bus_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    initial begin
        int sdiv = 0;
        forever begin
            @(negedge clk);
            sdiv++;
            if (sdiv >= slow_per) begin sdiv = 0; slow_tick = 1'b1; end
            else slow_tick = 1'b0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (wdt_rst) wdt_pulses++;
    end

    task automatic wr(input int a, input int d);
        bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string tag);
        bus_addr = 3'(a);
        #1;
        check(int'(bus_rdata) == exp, tag, bus_rdata, exp);
    endtask

    task automatic wait_evt(input bit sel, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(sel ? evt_b : evt_a) && n < 2000);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL all-reqs watchdog actual=expired expected=finished");
        done = 1'b1;
        report();
    end

    // ---------------- directed sequence ----------------
    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R4 reset state
        rd_check(4, 8'h00, "R4 ctrl after reset");
        rd_check(6, 8'h00, "R4 status after reset");
        rd_check(0, 8'h00, "R4 reload A low after reset");
        check(!irq_a && !irq_b && !irq_fix, "R4 irqs after reset", {irq_a, irq_b, irq_fix}, 0);

        // R1 reload byte readback
        wr(0, 8'h34); wr(1, 8'h12); wr(2, 8'hA5); wr(3, 8'h5A);
        rd_check(0, 8'h34, "R1 A low");
        rd_check(1, 8'h12, "R1 A high");
        rd_check(2, 8'hA5, "R1 B low");
        rd_check(3, 8'h5A, "R1 B high");
        rd_check(7, 8'h00, "R1 kick offset reads zero");

        // R2 timer A period on system clock: reload 4 -> 5 cycles
        wr(4, 8'h40);
        wr(0, 4); wr(1, 0);
        wr(4, 8'h45);
        wait_evt(1'b0, n);
        wait_evt(1'b0, n);
        check(n == 5, "R2 timer A period", n, 5);

        // R3 timer B on slow tick every 3 clocks: reload 2 -> 9 cycles
        slow_per = 3;
        wr(4, 8'h40);
        wr(2, 2); wr(3, 0);
        wr(4, 8'h5A);
        wait_evt(1'b1, n);
        wait_evt(1'b1, n);
        check(n == 9, "R3 timer B period on slow tick", n, 9);

        // R8 / R4 sticky flags, write-one-to-clear, irq gating
        wr(4, 8'h40);
        idle(3);
        rd_check(6, 8'h03, "R8 flags sticky after timers stop");
        check(irq_a == 1'b0, "R4 irq_a masked with flag set", irq_a, 0);
        wr(6, 8'h01);
        rd_check(6, 8'h02, "R8 write one clears A only");
        wr(6, 8'h00);
        rd_check(6, 8'h02, "R8 zero write ignored");
        wr(4, 8'h48);
        check(irq_b == 1'b1, "R4 irq_b follows flag and enable", irq_b, 1);
        wr(6, 8'h02);
        check(irq_b == 1'b0, "R8 irq_b drops after clear", irq_b, 0);
        rd_check(6, 8'h00, "R8 all flags clear");

        // R9 reload change while running applies at next reload
        slow_per = 1;
        wr(4, 8'h40);
        wr(0, 9); wr(1, 0);
        wr(4, 8'h41);
        wait_evt(1'b0, n);
        wr(0, 2);
        wait_evt(1'b0, n);
        check(n + 1 == 10, "R9 current period keeps old reload", n + 1, 10);
        wait_evt(1'b0, n);
        check(n == 3, "R9 next period uses new reload", n, 3);
        wr(4, 8'h40);

        // R5 rate ticker, watchdog off throughout (R10 window)
        wdt_pulses = 0;
        wr(6, 8'h07);
        wr(4, 8'h60);
        wr(5, 8'h08);
        idle(500);
        rd_check(6, 8'h00, "R5 code 8 not yet at 512 ticks");
        idle(30);
        rd_check(6, 8'h04, "R5 code 8 fires at 512 ticks");
        check(irq_fix == 1'b1, "R5 irq_fix raised", irq_fix, 1);
        wr(5, 8'h00);
        wr(6, 8'h04);
        idle(600);
        rd_check(6, 8'h00, "R5 ticker off gives no event");
        wr(5, 8'h0A);
        idle(2000);
        rd_check(6, 8'h00, "R5 code 10 not yet at 2048 ticks");
        idle(100);
        rd_check(6, 8'h04, "R5 code 10 fires at 2048 ticks");
        wr(5, 8'h00);
        idle(62700);
        check(wdt_pulses == 0, "R10 disabled watchdog stays quiet", wdt_pulses, 0);

        // R7 / R6 watchdog kick and timeout
        wdt_pulses = 0;
        wr(4, 8'h00);
        idle(30000);
        wr(7, 8'h5C);
        idle(36000);
        check(wdt_pulses == 0, "R7 kick restarts watchdog", wdt_pulses, 0);
        idle(29600);
        check(wdt_pulses == 1, "R6 single timeout pulse", wdt_pulses, 1);

        done = 1'b1;
        report();
    end

endmodule